// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Supervisor

This block is the digital decision-maker beside an input-power pass switch. It takes comparator results that are already digital: the two lockout levels, undervoltage, the undervoltage-reset level, overvoltage, output feedback, gate overdrive, temperature and a circuit-breaker trip. From these it decides when the switch gate may be driven. When the gate is off, it selects a slow or a fast discharge. It also drives two open-drain flags, one for faults and one for power good. A clock enable (`tick`) supplies the time base, and every interval is counted in ticks.

The block holds the power-on reset and the insertion debounce. It also holds the overcurrent fault latch and the rules for restart. A fault stays latched until the undervoltage-reset pin is held low long enough and then released. If the fault flag is wired back to that pin, the part retries on its own.

Top module: `hs_supervisor`

## Requirements
- R1: While `rail_lo` is high, and for POR_TICKS ticks after it falls, the gate is off and the fault latch, cooling state, thermal hold and debounce are all cleared.
- R2: The gate turns on only after DBC_TICKS consecutive ticks in which `uv_low`, `ov_hi`, `supply_lo` and `rail_lo` are all low and no fault or cooling is pending. Any `uv_low` or lockout during the count restarts it.
- R3: Whenever the gate is off, `gate_fast`=1 if `supply_lo` or `rail_lo` is high, and `gate_fast`=0 otherwise.
- R4: In the cycle after `cb_trip` is seen high, `gate_en`=0 and the fault latch is set.
- R5: The fault latch clears only when `uvr_ok` has been low for at least UVR_MIN_TICKS ticks and then returns high. A shorter low leaves the latch set.
- R6: The gate stays off while the latch is set or cooling is pending. Cooling is pending from the trip until `cool_done`. Once both are clear, a full debounce is needed again.
- R7: Once the debounce has completed, an overvoltage turns the gate off, and the gate returns as soon as `ov_hi` falls, with no new debounce.
- R8: `pg_pd`=0 (flag released) only while the gate is on and both `fb_good` and `ovd_good` are high. Otherwise `pg_pd`=1.
- R9: `temp_hot` holds the gate off from the next cycle. The hold ends only when `temp_cool` is seen.
- R10: `flt_pd`=1 (flag pulled low) while the fault latch is set and cooling is still pending. It is released when either of the two ends.
- R11: With the fault flag wired to the undervoltage and undervoltage-reset inputs, each trip is followed by a restart once `cool_done` arrives and a debounce has run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base clock enable |
| supply_lo | input | 1 | Supply lockout active |
| rail_lo | input | 1 | Internal-rail lockout active |
| uv_low | input | 1 | Undervoltage detected |
| uvr_ok | input | 1 | Undervoltage pin above its reset threshold |
| ov_hi | input | 1 | Overvoltage detected |
| fb_good | input | 1 | Output feedback above its good threshold |
| ovd_good | input | 1 | Gate overdrive above its threshold |
| temp_hot | input | 1 | Over-temperature trip |
| temp_cool | input | 1 | Temperature back below its release point |
| cb_trip | input | 1 | Circuit-breaker timer expired |
| cool_done | input | 1 | Cool-down timer finished |
| gate_en | output | 1 | Gate drive on (slow ramp) |
| gate_fast | output | 1 | Fast discharge selected while off |
| flt_pd | output | 1 | Fault flag pull-down enable |
| pg_pd | output | 1 | Power-good flag pull-down enable |

## Verification
The bench injects an undervoltage glitch partway through the debounce. A design that did not restart the count would switch on early. It pulls the reset pin low for too short a time, which a design with a plain edge detector would wrongly accept as a latch clear. It also clears the latch before the cool-down ends, which catches a design that restarts without waiting for the cool-down. Further cases cover the immediate return after an overvoltage clears and the slow-versus-fast discharge choice. Last, the bench closes the fault-flag loopback and counts repeated restarts, where a flag that stayed low for as long as the latch was set would deadlock.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [1:0] {
    GD_OFF_SLOW = 2'd0,
    GD_OFF_FAST = 2'd1,
    GD_ON       = 2'd2
  } gate_mode_e;

  function automatic int unsigned cntw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/por_gen.sv
module por_gen #(
  parameter int unsigned POR_TICKS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rail_lo,
  output logic por
);
  localparam int unsigned W = hsw_pkg::cntw(POR_TICKS);
  localparam logic [W-1:0] LAST = W'(POR_TICKS - 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      por <= 1'b1;
    end else if (rail_lo) begin
      cnt <= '0;
      por <= 1'b1;
    end else if (por && tick) begin
      if (cnt == LAST) por <= 1'b0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uvr_clear.sv
module uvr_clear #(
  parameter int unsigned MIN_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic uvr_ok,
  output logic clr
);
  localparam int unsigned W = hsw_pkg::cntw(MIN_TICKS);
  localparam logic [W-1:0] SAT = W'(MIN_TICKS);
  logic [W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      clr     <= 1'b0;
    end else if (!uvr_ok) begin
      clr <= 1'b0;
      if (tick && low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
    end else begin
      clr     <= (low_cnt == SAT);
      low_cnt <= '0;
    end
  end
endmodule

// File: rtl/insert_dbc.sv
module insert_dbc #(
  parameter int unsigned DBC_TICKS = 48000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic qual,
  output logic armed
);
  localparam int unsigned W = hsw_pkg::cntw(DBC_TICKS);
  localparam logic [W-1:0] LAST = W'(DBC_TICKS - 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!armed) begin
      if (!qual)     cnt <= '0;
      else if (tick) begin
        if (cnt == LAST) armed <= 1'b1;
        else             cnt   <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hs_supervisor.sv
module hs_supervisor #(
  parameter int unsigned POR_TICKS     = 25,
  parameter int unsigned DBC_TICKS     = 48000,
  parameter int unsigned UVR_MIN_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_lo,
  input  logic rail_lo,
  input  logic uv_low,
  input  logic uvr_ok,
  input  logic ov_hi,
  input  logic fb_good,
  input  logic ovd_good,
  input  logic temp_hot,
  input  logic temp_cool,
  input  logic cb_trip,
  input  logic cool_done,
  output logic gate_en,
  output logic gate_fast,
  output logic flt_pd,
  output logic pg_pd
);
  import hsw_pkg::*;

  logic por, armed, uvr_clr;
  logic latch_q, cool_q, hot_q;
  logic restart, qual, gate_ok, lockout;
  gate_mode_e mode;

  por_gen #(.POR_TICKS(POR_TICKS)) u_por (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rail_lo(rail_lo), .por(por)
  );

  uvr_clear #(.MIN_TICKS(UVR_MIN_TICKS)) u_uvr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uvr_ok(uvr_ok), .clr(uvr_clr)
  );

  assign lockout = supply_lo | rail_lo;
  assign restart = por | uv_low | lockout | cb_trip;
  assign qual    = ~ov_hi & ~latch_q & ~cool_q;

  insert_dbc #(.DBC_TICKS(DBC_TICKS)) u_dbc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
    .qual(qual), .armed(armed)
  );

  // fault latch, cool-down pending, thermal hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      cool_q  <= 1'b0;
      hot_q   <= 1'b0;
    end else if (por) begin
      latch_q <= 1'b0;
      cool_q  <= 1'b0;
      hot_q   <= 1'b0;
    end else begin
      if (cb_trip)      latch_q <= 1'b1;
      else if (uvr_clr) latch_q <= 1'b0;

      if (cb_trip)        cool_q <= 1'b1;
      else if (cool_done) cool_q <= 1'b0;

      if (temp_hot)       hot_q <= 1'b1;
      else if (temp_cool) hot_q <= 1'b0;
    end
  end

  // turn-off is combinational on live inputs; turn-on needs registered state
  assign gate_ok = armed & ~latch_q & ~cool_q & ~hot_q & ~por &
                   ~ov_hi & ~uv_low & ~lockout;

  always_comb begin
    if (gate_ok)      mode = GD_ON;
    else if (lockout) mode = GD_OFF_FAST;
    else              mode = GD_OFF_SLOW;
  end

  assign gate_en   = (mode == GD_ON);
  assign gate_fast = (mode == GD_OFF_FAST);
  assign flt_pd    = latch_q & cool_q;
  assign pg_pd     = ~(gate_en & fb_good & ovd_good);
endmodule

// File: rtl/hs_supervisor_chk.sv
module hs_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_lo,
  input logic rail_lo,
  input logic uv_low,
  input logic ov_hi,
  input logic fb_good,
  input logic ovd_good,
  input logic temp_hot,
  input logic cb_trip,
  input logic gate_en,
  input logic gate_fast,
  input logic flt_pd,
  input logic pg_pd
);
  // R4: trip removes the gate on the following cycle
  p_trip_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cb_trip |=> !gate_en);

  // R3: lockouts force the fast discharge
  p_fast_lockout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_lo || rail_lo) |-> (!gate_en && gate_fast));

  // R3: voltage faults without lockout use the slow discharge
  p_slow_volt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((uv_low || ov_hi) && !supply_lo && !rail_lo) |-> (!gate_en && !gate_fast));

  // R8: power good released only with gate on and both qualifiers
  p_pg_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_pd |-> (gate_en && fb_good && ovd_good));

  // R6: fault flag never coexists with a driven gate
  p_flt_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pd |-> !gate_en);

  // R9: over-temperature holds the gate off from the next cycle
  p_hot_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    temp_hot |=> !gate_en);
endmodule

bind hs_supervisor hs_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_lo(supply_lo), .rail_lo(rail_lo),
  .uv_low(uv_low), .ov_hi(ov_hi), .fb_good(fb_good), .ovd_good(ovd_good),
  .temp_hot(temp_hot), .cb_trip(cb_trip), .gate_en(gate_en),
  .gate_fast(gate_fast), .flt_pd(flt_pd), .pg_pd(pg_pd)
);

// File: tb/sim_hs_supervisor.sv
module sim_hs_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int POR_T = 4;
  localparam int DBC_T = 20;
  localparam int UVR_T = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick;
  logic supply_lo = 1'b0, rail_lo = 1'b1;
  logic ext_uv_low = 1'b0, ext_uvr_low = 1'b0, loop_en = 1'b0;
  logic ov_hi = 1'b0, fb_good = 1'b0, ovd_good = 1'b0;
  logic temp_hot = 1'b0, temp_cool = 1'b0, cb_trip = 1'b0, cool_done = 1'b0;
  logic gate_en, gate_fast, flt_pd, pg_pd;
  logic uv_low_w, uvr_ok_w;
  int n_tests = 0, n_fail = 0, restarts = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;

  // open-drain loopback of the fault flag onto the undervoltage pin
  assign uv_low_w = ext_uv_low | (loop_en & flt_pd);
  assign uvr_ok_w = ~(ext_uvr_low | (loop_en & flt_pd));

  hs_supervisor #(.POR_TICKS(POR_T), .DBC_TICKS(DBC_T), .UVR_MIN_TICKS(UVR_T)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_lo(supply_lo),
    .rail_lo(rail_lo), .uv_low(uv_low_w), .uvr_ok(uvr_ok_w), .ov_hi(ov_hi),
    .fb_good(fb_good), .ovd_good(ovd_good), .temp_hot(temp_hot),
    .temp_cool(temp_cool), .cb_trip(cb_trip), .cool_done(cool_done),
    .gate_en(gate_en), .gate_fast(gate_fast), .flt_pd(flt_pd), .pg_pd(pg_pd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic pulse_trip();
    cb_trip = 1'b1; @(negedge clk); cb_trip = 1'b0;
  endtask

  task automatic pulse_cool();
    cool_done = 1'b1; @(negedge clk); cool_done = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 gate in reset", gate_en, 0);
    chk("R10 flag in reset", flt_pd, 0);
    chk("R8 pg in reset", pg_pd, 1);
    rst_n = 1'b1;
    wt(10);
    chk("R1 gate held by rail lockout", gate_en, 0);
    chk("R3 fast while rail lockout", gate_fast, 1);
  endtask

  task automatic t_power_up();
    rail_lo = 1'b0;
    wt(POR_T + DBC_T - 2);
    chk("R2 off before debounce end", gate_en, 0);
    wt(6);
    chk("R2 on after por plus debounce", gate_en, 1);
    chk("R8 pg low without qualifiers", pg_pd, 1);
    fb_good = 1'b1; ovd_good = 1'b1; @(negedge clk);
    chk("R8 pg released", pg_pd, 0);
    ovd_good = 1'b0; @(negedge clk);
    chk("R8 pg needs overdrive", pg_pd, 1);
    ovd_good = 1'b1; fb_good = 1'b0; @(negedge clk);
    chk("R8 pg drops with feedback", pg_pd, 1);
    fb_good = 1'b1; @(negedge clk);
  endtask

  task automatic t_dbc_restart();
    ext_uv_low = 1'b1; @(negedge clk);
    chk("R3 uv off", gate_en, 0);
    chk("R3 uv slow discharge", gate_fast, 0);
    chk("R8 pg low when gate off", pg_pd, 1);
    ext_uv_low = 1'b0;
    wt(15);
    ext_uv_low = 1'b1; @(negedge clk); ext_uv_low = 1'b0;
    wt(15);
    chk("R2 glitch restarts count", gate_en, 0);
    wt(8);
    chk("R2 on after restarted count", gate_en, 1);
  endtask

  task automatic t_ov();
    ov_hi = 1'b1; @(negedge clk);
    chk("R3 ov off", gate_en, 0);
    chk("R3 ov slow discharge", gate_fast, 0);
    wt(30);
    ov_hi = 1'b0; @(negedge clk);
    chk("R7 immediate return after ov", gate_en, 1);
  endtask

  task automatic t_lockout();
    supply_lo = 1'b1; @(negedge clk);
    chk("R3 supply lockout off", gate_en, 0);
    chk("R3 supply lockout fast", gate_fast, 1);
    supply_lo = 1'b0;
    wt(5);
    chk("R2 lockout needs debounce", gate_en, 0);
    wt(20);
    chk("R2 on after lockout debounce", gate_en, 1);
  endtask

  task automatic t_trip_latch();
    pulse_trip();
    chk("R4 trip off", gate_en, 0);
    chk("R10 flag on trip", flt_pd, 1);
    wt(5);
    pulse_cool();
    chk("R10 flag released on cool-down", flt_pd, 0);
    wt(30);
    chk("R6 latch holds off", gate_en, 0);
    ext_uv_low = 1'b1; ext_uvr_low = 1'b1;
    repeat (2) @(negedge clk);
    ext_uv_low = 1'b0; ext_uvr_low = 1'b0;
    wt(30);
    chk("R5 short reset low ignored", gate_en, 0);
    ext_uv_low = 1'b1; ext_uvr_low = 1'b1;
    wt(5);
    ext_uv_low = 1'b0; ext_uvr_low = 1'b0;
    wt(10);
    chk("R6 debounce after clear", gate_en, 0);
    wt(14);
    chk("R5 latch cleared by long low", gate_en, 1);
  endtask

  task automatic t_cool_first();
    pulse_trip();
    chk("R4 second trip off", gate_en, 0);
    ext_uv_low = 1'b1; ext_uvr_low = 1'b1;
    wt(5);
    ext_uv_low = 1'b0; ext_uvr_low = 1'b0;
    wt(2);
    chk("R10 flag released on latch clear", flt_pd, 0);
    wt(30);
    chk("R6 cooling pending holds off", gate_en, 0);
    pulse_cool();
    wt(10);
    chk("R6 debounce after cool-down", gate_en, 0);
    wt(14);
    chk("R6 on after cool-down and debounce", gate_en, 1);
  endtask

  task automatic t_hot();
    temp_hot = 1'b1; @(negedge clk); temp_hot = 1'b0;
    chk("R9 hot off", gate_en, 0);
    wt(10);
    chk("R9 hold until cool flag", gate_en, 0);
    temp_cool = 1'b1; @(negedge clk); temp_cool = 1'b0;
    @(negedge clk);
    chk("R9 on after cool flag", gate_en, 1);
  endtask

  task automatic t_autoretry();
    loop_en = 1'b1;
    for (int i = 0; i < 2; i++) begin
      pulse_trip();
      chk("R11 trip flag", flt_pd, 1);
      chk("R11 trip off", gate_en, 0);
      wt(10);
      pulse_cool();
      wt(10);
      chk("R11 debounce before retry", gate_en, 0);
      wt(16);
      chk("R11 retry on", gate_en, 1);
      if (gate_en) restarts++;
    end
    chk("R11 restart count", restarts, 2);
    loop_en = 1'b0;
  endtask

  task automatic t_rail_por();
    pulse_trip();
    chk("R4 trip before rail drop", flt_pd, 1);
    rail_lo = 1'b1; @(negedge clk);
    chk("R3 rail lockout fast", gate_fast, 1);
    wt(2);
    rail_lo = 1'b0;
    wt(2);
    chk("R1 reset pulse clears latch", flt_pd, 0);
    wt(POR_T + DBC_T + 4);
    chk("R1 restart after reset pulse", gate_en, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_power_up();
    t_dbc_restart();
    t_ov();
    t_lockout();
    t_trip_latch();
    t_cool_first();
    t_hot();
    t_autoretry();
    t_rail_por();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule